// File: doc/BRIEF.md
# Single-Level Page Table Translator

This block maps a 16-bit virtual address to a physical address through a page table kept in memory. A processor-side request presents a virtual address and a read/write flag with a valid/ready handshake. The translator then reads one table entry over a memory read port. It produces one of two results for exactly one cycle: a translated physical address, or a fault. Nothing is cached, so every request costs one table read.

The table's physical location sits in a base register. Only privileged software can load it. Loading a new base switches the whole mapping at once, for example when the running process changes or when execution enters or leaves the kernel. A load attempted without privilege leaves the register untouched and raises a one-cycle denial flag.

When an entry is invalid, the translator keeps the offending virtual address in a readable register so the fault handler can inspect it.

Top module: `pagexlat_top`

## Requirements
- R1: A virtual address splits into a page number P (bits 15:9) and an offset (bits 8:0). The entry is read from `memRdAddr` = base + P, a 16-bit sum that wraps modulo 65536.
- R2: When bit 0 of the returned entry byte is 1, `xlatValid` pulses. `xlatAddr` equals entry bits 7:1 placed in physical bits 15:9, with the unchanged offset in bits 8:0, and `xlatFault` stays 0.
- R3: When bit 0 of the entry is 0, `xlatFault` pulses and `xlatValid` stays 0. `xlatValid` and `xlatFault` are never high together.
- R4: In the cycle a fault is presented, `faultAddr` holds that request's virtual address. It changes at no other time.
- R5: A base load with `privMode` = 1 takes effect for every request accepted after the loading clock edge.
- R6: A base load with `privMode` = 0 leaves the mapping unchanged. One cycle later, `baseWrDenied` is 1 for exactly one cycle.
- R7: `reqReady` is 1 only while idle. It is 0 from the edge that accepts a request through the result cycle, so no new request is accepted while a table read is outstanding.
- R8: Each accepted request causes exactly one table read. `memRdReq` rises the cycle after acceptance and stays high, with a stable address, until `memRdAck`. No read happens without a request.
- R9: The result pulse lasts exactly one cycle. It comes the cycle after `memRdAck`, and `xlatWrite` then equals the request's write flag.
- R10: After reset, `reqReady` = 1, `memRdReq` = 0, both result pulses are 0, `faultAddr` = 0, `baseWrDenied` = 0, and the base register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Translator can accept a request |
| reqAddr | input | 16 | Virtual address |
| reqWrite | input | 1 | Request is a write access |
| privMode | input | 1 | Processor is in privileged mode |
| baseWrEn | input | 1 | Load the table base register |
| baseWrData | input | 16 | New table base (physical address) |
| baseWrDenied | output | 1 | Base load was refused (one-cycle pulse) |
| memRdReq | output | 1 | Table entry read outstanding |
| memRdAddr | output | 16 | Physical address of the entry |
| memRdAck | input | 1 | Entry data valid this cycle |
| memRdData | input | 8 | Entry byte |
| xlatValid | output | 1 | Translation succeeded (one-cycle pulse) |
| xlatFault | output | 1 | Entry invalid (one-cycle pulse) |
| xlatAddr | output | 16 | Translated physical address |
| xlatWrite | output | 1 | Write flag of the translated request |
| faultAddr | output | 16 | Virtual address of the most recent fault |

## Verification
The checker watches the handshake and sequencing rules on every cycle. It confirms that ready stays low while a read is outstanding, that the read address holds until acknowledge, that the result pulses are single-cycle and mutually exclusive, that a refused base load is flagged, and that the fault register moves only with a fault. The arithmetic content can only be shown by the bench's scenarios. That covers the wrapped base-plus-page address, the frame and offset splice, the captured faulting address, and whether a privileged or refused base load actually changes later translations.

// File: rtl/pagexlat_pkg.sv
package pagexlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FETCH  = 2'd1,
    ST_RESULT = 2'd2
  } xlatState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;   // latch request and compute entry address
    logic capture;  // entry byte returned, form the result
  } xlatStrobe_t;
endpackage

// File: rtl/pagexlat_ctrl.sv
module pagexlat_ctrl
  import pagexlat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        memRdAck,
  output logic        reqReady,
  output logic        memRdReq,
  output xlatStrobe_t strobe
);
  xlatState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_FETCH;
      ST_FETCH:  if (memRdAck) stateNext = ST_RESULT;
      ST_RESULT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady       = (state == ST_IDLE);
  assign memRdReq       = (state == ST_FETCH);
  assign strobe.accept  = (state == ST_IDLE) && reqValid;
  assign strobe.capture = (state == ST_FETCH) && memRdAck;
endmodule

// File: rtl/pagexlat_dpath.sv
module pagexlat_dpath
  import pagexlat_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 9,
  parameter int ENT_W = 8,
  parameter int TA_W  = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  xlatStrobe_t                strobe,
  input  logic [VA_W-1:0]            reqAddr,
  input  logic                       reqWrite,
  input  logic                       privMode,
  input  logic                       baseWrEn,
  input  logic [TA_W-1:0]            baseWrData,
  input  logic [ENT_W-1:0]           memRdData,
  output logic [TA_W-1:0]            memRdAddr,
  output logic                       xlatValid,
  output logic                       xlatFault,
  output logic [ENT_W-1+OFF_W-1:0]   xlatAddr,
  output logic                       xlatWrite,
  output logic [VA_W-1:0]            faultAddr,
  output logic                       baseWrDenied
);
  localparam int PN_W    = VA_W - OFF_W;
  localparam int FRAME_W = ENT_W - 1;
  localparam int PA_W    = FRAME_W + OFF_W;

  logic [TA_W-1:0] baseReg;
  logic [VA_W-1:0] vaReg;
  logic            wrReg;
  logic [TA_W-1:0] pageIdx;
  logic            entryOk;

  assign pageIdx = {{(TA_W-PN_W){1'b0}}, reqAddr[VA_W-1:OFF_W]};
  assign entryOk = memRdData[0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg      <= '0;
      baseWrDenied <= 1'b0;
    end else begin
      baseWrDenied <= baseWrEn && !privMode;
      if (baseWrEn && privMode) baseReg <= baseWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaReg     <= '0;
      wrReg     <= 1'b0;
      memRdAddr <= '0;
    end else if (strobe.accept) begin
      vaReg     <= reqAddr;
      wrReg     <= reqWrite;
      memRdAddr <= baseReg + pageIdx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xlatValid <= 1'b0;
      xlatFault <= 1'b0;
      xlatAddr  <= '0;
      xlatWrite <= 1'b0;
      faultAddr <= '0;
    end else if (strobe.capture) begin
      xlatValid <= entryOk;
      xlatFault <= !entryOk;
      xlatWrite <= wrReg;
      xlatAddr  <= entryOk ? {memRdData[ENT_W-1:1], vaReg[OFF_W-1:0]} : {PA_W{1'b0}};
      if (!entryOk) faultAddr <= vaReg;
    end else begin
      xlatValid <= 1'b0;
      xlatFault <= 1'b0;
    end
  end
endmodule

// File: rtl/pagexlat_top.sv
module pagexlat_top
  import pagexlat_pkg::*;
#(
  parameter int VA_W  = 16,
  parameter int OFF_W = 9,
  parameter int ENT_W = 8,
  parameter int TA_W  = 16,
  localparam int PA_W = ENT_W - 1 + OFF_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqAddr,
  input  logic             reqWrite,
  input  logic             privMode,
  input  logic             baseWrEn,
  input  logic [TA_W-1:0]  baseWrData,
  output logic             baseWrDenied,
  output logic             memRdReq,
  output logic [TA_W-1:0]  memRdAddr,
  input  logic             memRdAck,
  input  logic [ENT_W-1:0] memRdData,
  output logic             xlatValid,
  output logic             xlatFault,
  output logic [PA_W-1:0]  xlatAddr,
  output logic             xlatWrite,
  output logic [VA_W-1:0]  faultAddr
);
  xlatStrobe_t strobe;

  pagexlat_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .memRdAck (memRdAck),
    .reqReady (reqReady),
    .memRdReq (memRdReq),
    .strobe   (strobe)
  );

  pagexlat_dpath #(
    .VA_W (VA_W), .OFF_W(OFF_W), .ENT_W(ENT_W), .TA_W(TA_W)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .privMode     (privMode),
    .baseWrEn     (baseWrEn),
    .baseWrData   (baseWrData),
    .memRdData    (memRdData),
    .memRdAddr    (memRdAddr),
    .xlatValid    (xlatValid),
    .xlatFault    (xlatFault),
    .xlatAddr     (xlatAddr),
    .xlatWrite    (xlatWrite),
    .faultAddr    (faultAddr),
    .baseWrDenied (baseWrDenied)
  );
endmodule

// File: rtl/pagexlat_chk.sv
module pagexlat_chk #(
  parameter int VA_W = 16,
  parameter int TA_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic            reqValid,
  input logic            reqReady,
  input logic            memRdReq,
  input logic            memRdAck,
  input logic [TA_W-1:0] memRdAddr,
  input logic            xlatValid,
  input logic            xlatFault,
  input logic [VA_W-1:0] faultAddr,
  input logic            baseWrEn,
  input logic            privMode,
  input logic            baseWrDenied
);
  // R7
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq || xlatValid || xlatFault) |-> !reqReady);

  // R8
  accept_starts_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> memRdReq);

  // R8
  read_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && !memRdAck) |=> (memRdReq && $stable(memRdAddr)));

  // R9
  ack_gives_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memRdReq && memRdAck) |=> (xlatValid || xlatFault));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xlatValid || xlatFault) |=> !(xlatValid || xlatFault));

  // R3
  exclusive_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(xlatValid && xlatFault));

  // R4
  fault_addr_moves_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(faultAddr) |-> xlatFault);

  // R6
  denied_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (baseWrEn && !privMode) |=> baseWrDenied);

  // R6
  denied_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    baseWrDenied |-> $past(baseWrEn && !privMode));
endmodule

bind pagexlat_top pagexlat_chk #(.VA_W(VA_W), .TA_W(TA_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .memRdReq     (memRdReq),
  .memRdAck     (memRdAck),
  .memRdAddr    (memRdAddr),
  .xlatValid    (xlatValid),
  .xlatFault    (xlatFault),
  .faultAddr    (faultAddr),
  .baseWrEn     (baseWrEn),
  .privMode     (privMode),
  .baseWrDenied (baseWrDenied)
);

// File: tb/pagexlat_tb.sv
module pagexlat_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqAddr = '0;
  logic        reqWrite = 1'b0;
  logic        privMode = 1'b0;
  logic        baseWrEn = 1'b0;
  logic [15:0] baseWrData = '0;
  logic        baseWrDenied;
  logic        memRdReq;
  logic [15:0] memRdAddr;
  logic        memRdAck;
  logic [7:0]  memRdData;
  logic        xlatValid;
  logic        xlatFault;
  logic [15:0] xlatAddr;
  logic        xlatWrite;
  logic [15:0] faultAddr;

  always #4 clk = ~clk;  // 125 MHz

  pagexlat_top dut_i (.*);

  int checks = 0;
  int fails  = 0;
  int memLat = 0;
  int fetchCount = 0;
  int waitCnt = 0;
  logic [15:0] lastFetch = '0;
  logic [15:0] modelBase = '0;
  logic [15:0] expFaultVa = '0;
  bit done = 0;

  // table content: frame = a[6:0]^a[13:7], valid = a[0]^a[5]
  function automatic logic [7:0] entryFor(logic [15:0] a);
    return {a[6:0] ^ a[13:7], a[0] ^ a[5]};
  endfunction

  // memory model: ack after memLat wait cycles, one-cycle ack
  always @(posedge clk) begin
    if (!rstN) begin
      memRdAck  <= 1'b0;
      memRdData <= '0;
      waitCnt   <= 0;
    end else if (memRdAck) begin
      memRdAck <= 1'b0;
    end else if (memRdReq) begin
      if (waitCnt >= memLat) begin
        memRdAck   <= 1'b1;
        memRdData  <= entryFor(memRdAddr);
        lastFetch  <= memRdAddr;
        fetchCount <= fetchCount + 1;
        waitCnt    <= 0;
      end else begin
        waitCnt <= waitCnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadBase(input logic [15:0] val, input logic priv);
    @(negedge clk);
    baseWrEn = 1'b1; baseWrData = val; privMode = priv;
    @(negedge clk);
    baseWrEn = 1'b0; privMode = 1'b0;
    if (priv) modelBase = val;
    // R6: denial flag visible one cycle after the attempt
    chk(baseWrDenied == !priv, "R6 deny flag", {31'b0, baseWrDenied}, {31'b0, !priv});
    @(negedge clk);
    chk(baseWrDenied == 1'b0, "R6 deny pulse width", {31'b0, baseWrDenied}, 32'd0);
  endtask

  task automatic translate(input logic [15:0] va, input logic wr, input int lat);
    logic [15:0] expFetch;
    logic [7:0]  ent;
    int          startFetch;
    int          cyc;
    bit          readyBad;
    expFetch   = modelBase + {9'b0, va[15:9]};
    ent        = entryFor(expFetch);
    memLat     = lat;
    startFetch = fetchCount;
    @(negedge clk);
    chk(reqReady == 1'b1, "R7 ready when idle", {31'b0, reqReady}, 32'd1);
    reqValid = 1'b1; reqAddr = va; reqWrite = wr;
    @(negedge clk);
    // hold a second request: must not be accepted while busy
    reqAddr = ~va;
    cyc = 0; readyBad = 0;
    while (!(xlatValid || xlatFault) && cyc < 40) begin
      if (reqReady) readyBad = 1;
      @(negedge clk);
      cyc++;
    end
    reqValid = 1'b0;
    chk(!readyBad, "R7 ready low while busy", {31'b0, readyBad}, 32'd0);
    chk(cyc == lat + 2, "R9 result timing", cyc, lat + 2);
    chk(lastFetch == expFetch, "R1 entry address", {16'b0, lastFetch}, {16'b0, expFetch});
    chk(fetchCount == startFetch + 1, "R8 one read", fetchCount - startFetch, 1);
    chk(xlatWrite == wr, "R9 write flag", {31'b0, xlatWrite}, {31'b0, wr});
    if (ent[0]) begin
      chk(xlatValid && !xlatFault, "R2 valid result", {30'b0, xlatValid, xlatFault}, 32'b10);
      chk(xlatAddr == {ent[7:1], va[8:0]}, "R2 physical address",
          {16'b0, xlatAddr}, {16'b0, ent[7:1], va[8:0]});
    end else begin
      expFaultVa = va;
      chk(xlatFault && !xlatValid, "R3 fault result", {30'b0, xlatValid, xlatFault}, 32'b01);
    end
    chk(faultAddr == expFaultVa, "R4 fault address", {16'b0, faultAddr}, {16'b0, expFaultVa});
    @(negedge clk);
    chk(!xlatValid && !xlatFault, "R9 single pulse", {30'b0, xlatValid, xlatFault}, 32'd0);
    chk(reqReady == 1'b1, "R7 ready after result", {31'b0, reqReady}, 32'd1);
    chk(faultAddr == expFaultVa, "R4 fault address held", {16'b0, faultAddr}, {16'b0, expFaultVa});
  endtask

  typedef struct packed {
    logic [15:0] base;
    logic [15:0] va;
    logic        wr;
    logic [2:0]  lat;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0100, 16'h0000, 1'b0, 3'd0},
    '{16'h0100, 16'h0200, 1'b1, 3'd1},
    '{16'h0100, 16'hFE37, 1'b0, 3'd3},
    '{16'h2A40, 16'h1234, 1'b1, 3'd0},
    '{16'h2A40, 16'h81FF, 1'b0, 3'd2},
    '{16'h7F81, 16'h4C01, 1'b1, 3'd5},
    '{16'hFFF0, 16'hFFFF, 1'b0, 3'd1},
    '{16'hFFC1, 16'hC000, 1'b1, 3'd0}
  };

  initial begin
    int idleFetch;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(reqReady == 1'b1, "R10 ready", {31'b0, reqReady}, 32'd1);
    chk(memRdReq == 1'b0, "R10 no read", {31'b0, memRdReq}, 32'd0);
    chk(!xlatValid && !xlatFault, "R10 no result", {30'b0, xlatValid, xlatFault}, 32'd0);
    chk(faultAddr == 16'h0, "R10 fault address", {16'b0, faultAddr}, 32'd0);
    chk(baseWrDenied == 1'b0, "R10 deny flag", {31'b0, baseWrDenied}, 32'd0);
    // R10 base is zero: first translation fetches from P
    translate(16'h3A00, 1'b0, 0);

    // table walk (R1 R2 R3 R5)
    for (int i = 0; i < NVEC; i++) begin
      if (VECS[i].base != modelBase) loadBase(VECS[i].base, 1'b1);
      translate(VECS[i].va, VECS[i].wr, int'(VECS[i].lat));
    end

    // R1 wrap: base 0xFFF0 + P 0x7F wraps to 0x006F
    loadBase(16'hFFF0, 1'b1);
    translate(16'hFE00, 1'b0, 0);
    chk(lastFetch == 16'h006F, "R1 wrap", {16'b0, lastFetch}, 32'h006F);

    // R6 unprivileged load ignored: mapping still uses 0xFFF0
    loadBase(16'h1234, 1'b0);
    translate(16'h0400, 1'b1, 1);
    chk(lastFetch == 16'hFFF2, "R6 base unchanged", {16'b0, lastFetch}, 32'hFFF2);

    // R5 privileged reload switches mapping
    loadBase(16'h0800, 1'b1);
    translate(16'h0400, 1'b1, 0);
    chk(lastFetch == 16'h0802, "R5 new base", {16'b0, lastFetch}, 32'h0802);

    // R8 no read without a request
    idleFetch = fetchCount;
    repeat (10) @(negedge clk);
    chk(fetchCount == idleFetch && !memRdReq, "R8 idle no read", fetchCount - idleFetch, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule